// File: doc/BRIEF.md
# UART FIFO DMA Ready Signalling

This block drives the two active-low handshake outputs that a FIFO-based UART presents to an external DMA controller. One output tells the controller that receive data can be collected. The other tells it whether the transmit FIFO can accept more bytes. The block does not contain the FIFOs, the character-timeout counter or the DMA controller. It watches the occupancy counts, the programmed receive trigger code, a timeout pulse and the FIFO control byte, and it produces both outputs from registers clocked on the system clock.

The block has two modes, chosen by bit 3 of the FIFO control byte. In single-transfer mode both outputs are plain level compares on the FIFO counts. In block mode the transmit output reports only a full FIFO. The receive output becomes a latched state in block mode. It asserts when the trigger level is reached or a character timeout fires, and it releases only when the receive FIFO has drained. Between those events it holds its value. This lets the DMA controller empty the FIFO in one burst rather than byte by byte.

Top module: `uart_dma_ready`

## Requirements
- R1: Block mode is selected when bit 3 of `fifo_ctl` is 1. The other seven bits of `fifo_ctl` have no effect on either output.
- R2: In single-transfer mode, `rx_rdy_n` becomes 1 when `rx_count` is 0 and becomes 0 when `rx_count` is nonzero.
- R3: In block mode, an empty receive FIFO (`rx_count` = 0) drives `rx_rdy_n` to 1. This takes priority over a timeout pulse in the same cycle.
- R4: In block mode, `rx_count` at or above the trigger level drives `rx_rdy_n` to 0. With a 16-entry FIFO, `rx_trig` codes 0, 1, 2 and 3 select 1, 4, 8 and 14 bytes.
- R5: In block mode, an `rx_tmo` pulse while the receive FIFO is not empty drives `rx_rdy_n` to 0.
- R6: In block mode, with a nonzero count below the trigger level and no timeout, `rx_rdy_n` keeps its previous value.
- R7: On the first cycle of block mode after single-transfer mode, `rx_rdy_n` is recomputed from the current level. It becomes 0 if `rx_count` is at or above the trigger level and 1 otherwise, whatever its previous value.
- R8: In single-transfer mode, `tx_rdy_n` becomes 1 when `tx_count` is nonzero and 0 when it is 0.
- R9: In block mode, `tx_rdy_n` becomes 1 when `tx_count` equals the transmit FIFO capacity and 0 otherwise.
- R10: Both outputs are registered and change only one clock edge after their inputs. While `rst_n` is low at a clock edge, `rx_rdy_n` becomes 1, `tx_rdy_n` becomes 0 and the block returns to single-transfer mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_ctl | input | 8 | FIFO control byte; bit 3 selects block mode |
| rx_trig | input | 2 | Receive trigger code (1/4/8/14 bytes for 16 entries) |
| rx_count | input | $clog2(RX_DEPTH+1) | Receive FIFO occupancy |
| rx_tmo | input | 1 | Receive character-timeout pulse |
| tx_count | input | $clog2(TX_DEPTH+1) | Transmit FIFO occupancy |
| rx_rdy_n | output | 1 | Receive ready to DMA, active low |
| tx_rdy_n | output | 1 | Transmit ready indicator, active low |

## Verification
The bench builds the block with its default parameters: 16-entry receive and transmit FIFOs and 5-bit counts. With these values every trigger code can be reached, including the 14-byte level and the exact full count of 16 that separates the two transmit-mode answers. Its vector walk moves the receive count up and down across each trigger level, both with and without timeout pulses. It also leaves block mode and re-enters it, so that the latched receive state is seen to hold, to release and to be recomputed on entry.

// File: rtl/uart_dma_rdy_pkg.sv
// Shared definitions for the UART DMA ready-signalling block.
// Assumes trigger codes are meaningful for FIFOs of at least 4 entries.
package uart_dma_rdy_pkg;

    // Position of the block-mode select bit in the FIFO control byte.
    localparam int unsigned DMA_SEL_BIT = 3;

    // Receive trigger codes.
    typedef enum logic [1:0] {
        TRIG_SINGLE  = 2'd0,
        TRIG_QUARTER = 2'd1,
        TRIG_HALF    = 2'd2,
        TRIG_TOP     = 2'd3
    } rx_trig_e;

    // Byte count selected by a trigger code for a FIFO of the given depth.
    function automatic int unsigned trig_bytes(input logic [1:0] code,
                                               input int unsigned depth);
        case (rx_trig_e'(code))
            TRIG_SINGLE:  trig_bytes = 1;
            TRIG_QUARTER: trig_bytes = depth / 4;
            TRIG_HALF:    trig_bytes = depth / 2;
            default:      trig_bytes = depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rx_trig_decode.sv
// Converts the 2-bit receive trigger code into a byte threshold.
// Assumes DEPTH >= 4, so that every threshold is at least one byte.
module rx_trig_decode #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] level
);
    import uart_dma_rdy_pkg::*;

    // Pure decode from the code to a threshold.
    always_comb begin
        level = CNT_W'(trig_bytes(sel, DEPTH));
    end

endmodule

// File: rtl/rx_ready_ctrl.sv
// Receive-ready register. In single-transfer mode it follows FIFO emptiness.
// In block mode it latches: it sets on the trigger level or a timeout and
// clears only when the FIFO is empty. On entry to block mode it is
// recomputed from the level alone.
// Assumes level >= 1, so that an empty FIFO never meets the trigger.
module rx_ready_ctrl #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_mode,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] level,
    input  logic             tmo,
    output logic             rdy_n
);
    logic mode_q;
    logic nxt_rdy_n;
    logic empty;
    logic at_trig;

    assign empty   = (count == '0);
    assign at_trig = (count >= level);

    // Select the next value of the ready register from the mode rules.
    always_comb begin
        if (!blk_mode) begin
            nxt_rdy_n = empty;
        end else if (!mode_q) begin
            nxt_rdy_n = !at_trig;
        end else if (empty) begin
            nxt_rdy_n = 1'b1;
        end else if (at_trig || tmo) begin
            nxt_rdy_n = 1'b0;
        end else begin
            nxt_rdy_n = rdy_n;
        end
    end

    // Hold the ready state and the previous mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_n  <= 1'b1;
            mode_q <= 1'b0;
        end else begin
            rdy_n  <= nxt_rdy_n;
            mode_q <= blk_mode;
        end
    end

endmodule

// File: rtl/tx_ready_gen.sv
// Transmit-ready register. It shows "holds data" in single-transfer mode
// and "full" in block mode. Assumes count never exceeds DEPTH.
module tx_ready_gen #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_mode,
    input  logic [CNT_W-1:0] count,
    output logic             rdy_n
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    // Register the compare chosen by the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_n <= 1'b0;
        end else if (blk_mode) begin
            rdy_n <= (count == FULL_CNT);
        end else begin
            rdy_n <= (count != '0);
        end
    end

endmodule

// File: rtl/uart_dma_ready.sv
// Top of the UART DMA ready-signalling block. It decodes the mode bit and
// the trigger code and drives both registered active-low ready outputs.
// Assumes the counts come from FIFOs synchronous to clk.
module uart_dma_ready #(
    parameter int unsigned RX_DEPTH = 16,
    parameter int unsigned TX_DEPTH = 16,
    localparam int unsigned RX_CW  = $clog2(RX_DEPTH + 1),
    localparam int unsigned TX_CW  = $clog2(TX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       fifo_ctl,
    input  logic [1:0]       rx_trig,
    input  logic [RX_CW-1:0] rx_count,
    input  logic             rx_tmo,
    input  logic [TX_CW-1:0] tx_count,
    output logic             rx_rdy_n,
    output logic             tx_rdy_n
);
    import uart_dma_rdy_pkg::*;

    logic             blk_mode;
    logic [RX_CW-1:0] rx_level;
    logic             unused_ctl;

    // Extract the block-mode select; the rest of the byte is ignored.
    assign blk_mode   = fifo_ctl[DMA_SEL_BIT];
    assign unused_ctl = ^{fifo_ctl[7:DMA_SEL_BIT+1], fifo_ctl[DMA_SEL_BIT-1:0]};

    rx_trig_decode #(.DEPTH(RX_DEPTH), .CNT_W(RX_CW)) trig_i (
        .sel   (rx_trig),
        .level (rx_level)
    );

    rx_ready_ctrl #(.CNT_W(RX_CW)) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_mode (blk_mode),
        .count    (rx_count),
        .level    (rx_level),
        .tmo      (rx_tmo),
        .rdy_n    (rx_rdy_n)
    );

    tx_ready_gen #(.DEPTH(TX_DEPTH), .CNT_W(TX_CW)) tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_mode (blk_mode),
        .count    (tx_count),
        .rdy_n    (tx_rdy_n)
    );

endmodule

// File: rtl/uart_dma_ready_chk.sv
// Property checker for uart_dma_ready, attached with bind. It observes the
// top-level ports only.
module uart_dma_ready_chk #(
    parameter int unsigned RX_DEPTH = 16,
    parameter int unsigned TX_DEPTH = 16,
    localparam int unsigned RX_CW  = $clog2(RX_DEPTH + 1),
    localparam int unsigned TX_CW  = $clog2(TX_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       fifo_ctl,
    input logic [1:0]       rx_trig,
    input logic [RX_CW-1:0] rx_count,
    input logic             rx_tmo,
    input logic [TX_CW-1:0] tx_count,
    input logic             rx_rdy_n,
    input logic             tx_rdy_n
);
    import uart_dma_rdy_pkg::*;

    logic             blk;
    logic [RX_CW-1:0] thr;

    assign blk = fifo_ctl[3];

    // Reference threshold for the current code.
    always_comb thr = RX_CW'(trig_bytes(rx_trig, RX_DEPTH));

    // R10: reset values
    a_r10_reset_vals: assert property (@(posedge clk)
        !rst_n |=> (rx_rdy_n && !tx_rdy_n));

    // R2: single-transfer receive compare
    a_r2_single_rx: assert property (@(posedge clk) disable iff (!rst_n)
        !blk |=> (rx_rdy_n == ($past(rx_count) == '0)));

    // R3: block-mode release on empty
    a_r3_blk_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && rx_count == '0) |=> rx_rdy_n);

    // R4: block-mode assert at trigger level
    a_r4_blk_trig: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && rx_count >= thr) |=> !rx_rdy_n);

    // R5: block-mode assert on timeout with data
    a_r5_blk_tmo: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && $past(blk) && rx_tmo && rx_count != '0) |=> !rx_rdy_n);

    // R6: block-mode hold between events
    a_r6_blk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (blk && $past(blk) && rx_count != '0 && rx_count < thr && !rx_tmo)
        |=> $stable(rx_rdy_n));

    // R8: single-transfer transmit compare
    a_r8_single_tx: assert property (@(posedge clk) disable iff (!rst_n)
        !blk |=> (tx_rdy_n == ($past(tx_count) != '0)));

    // R9: block-mode transmit full flag
    a_r9_blk_tx: assert property (@(posedge clk) disable iff (!rst_n)
        blk |=> (tx_rdy_n == ($past(tx_count) == TX_CW'(TX_DEPTH))));

endmodule

bind uart_dma_ready uart_dma_ready_chk #(
    .RX_DEPTH (RX_DEPTH),
    .TX_DEPTH (TX_DEPTH)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_ctl (fifo_ctl),
    .rx_trig  (rx_trig),
    .rx_count (rx_count),
    .rx_tmo   (rx_tmo),
    .tx_count (tx_count),
    .rx_rdy_n (rx_rdy_n),
    .tx_rdy_n (tx_rdy_n)
);

// File: tb/uart_dma_ready_tb_top.sv
// Self-checking bench for uart_dma_ready. It walks a vector table, then runs
// directed checks for latency and reset.
module uart_dma_ready_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fifo_ctl = 8'h00;
    logic [1:0] rx_trig = 2'd0;
    logic [4:0] rx_count = 5'd0;
    logic       rx_tmo = 1'b0;
    logic [4:0] tx_count = 5'd0;
    logic       rx_rdy_n;
    logic       tx_rdy_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_dma_ready dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_ctl(fifo_ctl), .rx_trig(rx_trig),
        .rx_count(rx_count), .rx_tmo(rx_tmo), .tx_count(tx_count),
        .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n)
    );

    // Vector: ctl[22:15] trig[14:13] rxc[12:8] tmo[7] txc[6:2] erx[1] etx[0]
    localparam int NV = 23;
    localparam logic [22:0] VEC [NV] = '{
        {8'h00, 2'd0, 5'd0,  1'b0, 5'd0,  1'b1, 1'b0}, // R2 R8 empty
        {8'h00, 2'd0, 5'd3,  1'b0, 5'd5,  1'b0, 1'b1}, // R2 R8 data
        {8'hF7, 2'd0, 5'd0,  1'b0, 5'd16, 1'b1, 1'b1}, // R1 other bits ignored
        {8'h08, 2'd2, 5'd3,  1'b0, 5'd16, 1'b1, 1'b1}, // R7 entry below trig, R9 full
        {8'h08, 2'd2, 5'd7,  1'b0, 5'd15, 1'b1, 1'b0}, // R6 hold, R9 not full
        {8'h08, 2'd2, 5'd8,  1'b0, 5'd15, 1'b0, 1'b0}, // R4 trig 8
        {8'h08, 2'd2, 5'd5,  1'b0, 5'd15, 1'b0, 1'b0}, // R6 hold low
        {8'h08, 2'd2, 5'd1,  1'b0, 5'd15, 1'b0, 1'b0}, // R6 hold low
        {8'h08, 2'd2, 5'd0,  1'b0, 5'd15, 1'b1, 1'b0}, // R3 drain
        {8'h08, 2'd2, 5'd2,  1'b0, 5'd15, 1'b1, 1'b0}, // R6 hold high
        {8'h08, 2'd2, 5'd2,  1'b1, 5'd15, 1'b0, 1'b0}, // R5 timeout
        {8'h08, 2'd2, 5'd2,  1'b0, 5'd15, 1'b0, 1'b0}, // R6 hold after tmo
        {8'h08, 2'd2, 5'd0,  1'b1, 5'd15, 1'b1, 1'b0}, // R3 empty beats tmo
        {8'h08, 2'd3, 5'd13, 1'b0, 5'd15, 1'b1, 1'b0}, // R6 below 14
        {8'h08, 2'd3, 5'd14, 1'b0, 5'd15, 1'b0, 1'b0}, // R4 trig 14
        {8'h08, 2'd0, 5'd0,  1'b0, 5'd15, 1'b1, 1'b0}, // R3
        {8'h08, 2'd0, 5'd1,  1'b0, 5'd15, 1'b0, 1'b0}, // R4 trig 1
        {8'h08, 2'd1, 5'd0,  1'b0, 5'd15, 1'b1, 1'b0}, // R3
        {8'h08, 2'd1, 5'd3,  1'b0, 5'd15, 1'b1, 1'b0}, // R6 below 4
        {8'h08, 2'd1, 5'd4,  1'b0, 5'd15, 1'b0, 1'b0}, // R4 trig 4
        {8'h00, 2'd3, 5'd4,  1'b0, 5'd0,  1'b0, 1'b0}, // R2 R8 leave block mode
        {8'h08, 2'd3, 5'd4,  1'b0, 5'd0,  1'b1, 1'b0}, // R7 re-entry recompute
        {8'hF8, 2'd3, 5'd14, 1'b0, 5'd16, 1'b0, 1'b1}  // R1 R4 R9 extra bits
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", req, act, exp);
        end
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset rx", rx_rdy_n, 1'b1);
        check("R10 reset tx", tx_rdy_n, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            fifo_ctl = VEC[i][22:15];
            rx_trig  = VEC[i][14:13];
            rx_count = VEC[i][12:8];
            rx_tmo   = VEC[i][7];
            tx_count = VEC[i][6:2];
            @(negedge clk);
            check($sformatf("vector %0d rx (R1-style row)", i), rx_rdy_n, VEC[i][1]);
            check($sformatf("vector %0d tx", i), tx_rdy_n, VEC[i][0]);
        end

        // R10: one-edge latency; inputs change, outputs wait for the edge
        fifo_ctl = 8'h00; rx_count = 5'd0; tx_count = 5'd3; rx_tmo = 1'b0;
        #1;
        check("R10 latency rx before edge", rx_rdy_n, 1'b0);
        check("R10 latency tx before edge", tx_rdy_n, 1'b1);
        @(negedge clk);
        check("R2 after edge", rx_rdy_n, 1'b1);
        check("R8 after edge", tx_rdy_n, 1'b1);

        // R10: reset from a latched block-mode state
        fifo_ctl = 8'h08; rx_trig = 2'd0; rx_count = 5'd2; tx_count = 5'd16;
        @(negedge clk);
        check("R4 pre-reset", rx_rdy_n, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid reset rx", rx_rdy_n, 1'b1);
        check("R10 mid reset tx", tx_rdy_n, 1'b0);
        // R7: after reset the block re-enters block mode and recomputes
        rst_n = 1'b1; rx_trig = 2'd3; rx_count = 5'd5;
        @(negedge clk);
        check("R7 entry after reset", rx_rdy_n, 1'b1);
        check("R9 full after reset", tx_rdy_n, 1'b1);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired actual 0 expected 1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule